// File: doc/BRIEF.md
# External Interrupt Front End

This block takes 32 asynchronous pins, grouped into four banks of eight, and turns them into interrupt requests. Each pin has a programmable trigger type, a mask bit and a sticky pending bit. Inputs are synchronized, compared against their previous sampled value, and qualified by the trigger type. A qualifying event sets the pin's pending bit. Software clears a pending bit by writing a one to its position.

Pins 0 to 15, which are banks 0 and 1, each drive their own interrupt line, equal to the pin's pending bit gated by its mask bit. Pins 16 to 31, which are banks 2 and 3, are folded into one shared line. The handler reads the pending and mask registers of banks 2 and 3 to find which sources fired, scanning from the lowest bit upward.

Register access is a single-cycle synchronous write port with a combinational read. The address is `{bank[1:0], sel[1:0]}`, where sel 0 is the control word, sel 1 is the mask, sel 2 is the pending register, and sel 3 reads as zero.

Top module: `xint_front`

## Requirements
- R1: After reset every pending bit is 0, every mask bit is 1, every control word reads 0, and all interrupt outputs are low.
- R2: A pin's 3-bit trigger field lies at control bits [4*(pin mod 8)+2 : 4*(pin mod 8)] of bank pin/8. The fourth bit of each nibble is not stored and reads 0. Register select 3 reads 0.
- R3: Trigger code 1 (high level) sets pending on every cycle the synchronized pin is high, so the bit returns after a clear while the pin stays high.
- R4: Trigger code 0 (low level) sets pending while the synchronized pin is low.
- R5: Trigger code 3 (rising edge) sets pending only on a 0-to-1 change; a clear while the pin stays high keeps the bit clear.
- R6: Trigger code 2 (falling edge) sets pending only on a 1-to-0 change.
- R7: Trigger code 4 (both edges) sets pending on either change.
- R8: Trigger codes 5, 6 and 7 never set pending.
- R9: Writing 1 to a pending bit clears it and writing 0 leaves it unchanged. A set event in the same cycle as a clear leaves the bit set.
- R10: Pending is captured even while masked. A mask bit of 1 keeps that source off every interrupt output.
- R11: `irq_direct[n]` for n in 0..15 is high exactly when pin n is pending and unmasked.
- R12: `irq_shared` is high when any pin 16..31 is pending and unmasked.
- R13: A pin change driven before clock edge k shows in the pending register after edge k+2 and not after edge k+1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| pin_i | input | 32 | Asynchronous interrupt pins |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 4 | `{bank, sel}` register address |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Combinational read data |
| irq_direct | output | 16 | Per-pin interrupt lines for pins 0..15 |
| irq_shared | output | 1 | Combined interrupt line for pins 16..31 |

## Verification
The assertions assume that reset is asserted from time zero and that write data is stable around the rising edge at which a write is taken. They also assume that a pending bit can only appear from a detected event and can only disappear through a one written to it.

The stimulus changes pins and the register bus only on falling clock edges, so every synchronizer stage and write sees settled values. Pins are held low through reset. Level-type fields are programmed only while the pin sits at its inactive level, so any pending observed afterwards comes from the pattern under test.

// File: rtl/xint_pkg.sv
package xint_pkg;

    // Width of one trigger field and spacing of fields in a control word
    localparam int FIELD_W      = 3;
    localparam int FIELD_STRIDE = 4;

    typedef enum logic [FIELD_W-1:0] {
        TRIG_LOW  = 3'd0,
        TRIG_HIGH = 3'd1,
        TRIG_FALL = 3'd2,
        TRIG_RISE = 3'd3,
        TRIG_BOTH = 3'd4
    } trig_e;

    // Low two address bits choose the register inside a bank
    typedef enum logic [1:0] {
        SEL_CTRL = 2'd0,
        SEL_MASK = 2'd1,
        SEL_PEND = 2'd2,
        SEL_NONE = 2'd3
    } regsel_e;

    // Decide whether a source fires this cycle from its code and samples
    function automatic logic trig_fires(logic [FIELD_W-1:0] code,
                                        logic cur, logic prev);
        case (code)
            TRIG_LOW:  return !cur;
            TRIG_HIGH: return cur;
            TRIG_FALL: return prev && !cur;
            TRIG_RISE: return !prev && cur;
            TRIG_BOTH: return prev ^ cur;
            default:   return 1'b0;
        endcase
    endfunction

endpackage

// File: rtl/xint_sync.sv
// Two-flop synchronizer plus one history stage for edge comparison
module xint_sync #(
    parameter int WIDTH = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] pin_i,
    output logic [WIDTH-1:0] cur_o,
    output logic [WIDTH-1:0] prev_o
);

    typedef struct packed {
        logic [WIDTH-1:0] meta;
        logic [WIDTH-1:0] stable;
        logic [WIDTH-1:0] hist;
    } sync_t;

    sync_t st_d, st_q;

    always_comb begin
        st_d        = st_q;
        st_d.meta   = pin_i;
        st_d.stable = st_q.meta;
        st_d.hist   = st_q.stable;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign cur_o  = st_q.stable;
    assign prev_o = st_q.hist;

    // R13: history stage always follows the synchronized value by one cycle
    // R13
    hist_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> (st_q.hist == $past(st_q.stable)));

endmodule

// File: rtl/xint_detect.sv
// Per-pin trigger qualification, one lane per source of a bank
module xint_detect import xint_pkg::*; #(
    parameter int BANK_W = 8
) (
    input  logic [BANK_W-1:0][FIELD_W-1:0] code_i,
    input  logic [BANK_W-1:0]              cur_i,
    input  logic [BANK_W-1:0]              prev_i,
    output logic [BANK_W-1:0]              set_o
);

    for (genvar i = 0; i < BANK_W; i++) begin : g_lane
        assign set_o[i] = trig_fires(code_i[i], cur_i[i], prev_i[i]);
    end

endmodule

// File: rtl/xint_bank.sv
// Control, mask and pending state of one bank of sources
module xint_bank import xint_pkg::*; #(
    parameter  int BANK_W = 8,
    localparam int CTRL_W = BANK_W * FIELD_STRIDE
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [BANK_W-1:0] cur_i,
    input  logic [BANK_W-1:0] prev_i,
    input  logic              wr_ctrl_i,
    input  logic              wr_mask_i,
    input  logic              wr_pend_i,
    input  logic [CTRL_W-1:0] wdata_i,
    output logic [CTRL_W-1:0] ctrl_o,
    output logic [BANK_W-1:0] mask_o,
    output logic [BANK_W-1:0] pend_o,
    output logic [BANK_W-1:0] active_o
);

    localparam int PAD_W = FIELD_STRIDE - FIELD_W;

    typedef struct packed {
        logic [BANK_W-1:0][FIELD_W-1:0] ctrl;
        logic [BANK_W-1:0]              mask;
        logic [BANK_W-1:0]              pend;
    } bank_t;

    bank_t             st_d, st_q;
    logic [BANK_W-1:0] set_ev;
    logic [BANK_W-1:0] clr_vec;

    xint_detect #(.BANK_W(BANK_W)) detect_i (
        .code_i (st_q.ctrl),
        .cur_i  (cur_i),
        .prev_i (prev_i),
        .set_o  (set_ev)
    );

    assign clr_vec = wr_pend_i ? wdata_i[BANK_W-1:0] : '0;

    always_comb begin
        st_d = st_q;
        if (wr_ctrl_i) begin
            for (int i = 0; i < BANK_W; i++) begin
                st_d.ctrl[i] = wdata_i[i*FIELD_STRIDE +: FIELD_W];
            end
        end
        if (wr_mask_i) begin
            st_d.mask = wdata_i[BANK_W-1:0];
        end
        // a new event outranks a clear landing in the same cycle
        st_d.pend = (st_q.pend & ~clr_vec) | set_ev;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q.ctrl <= '0;
            st_q.mask <= '1;
            st_q.pend <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    // Spare nibble bits are not stored and read back as zero
    for (genvar i = 0; i < BANK_W; i++) begin : g_rd
        assign ctrl_o[i*FIELD_STRIDE +: FIELD_STRIDE] = {{PAD_W{1'b0}}, st_q.ctrl[i]};
    end

    logic unused_wbits;
    assign unused_wbits = ^wdata_i;

    assign mask_o   = st_q.mask;
    assign pend_o   = st_q.pend;
    assign active_o = st_q.pend & ~st_q.mask;

    // R9: a pending bit only appears after an event in the previous cycle
    // R9
    pend_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> ((st_q.pend & ~$past(st_q.pend) & ~$past(set_ev)) == '0));

    // R9: a pending bit only vanishes after a one was written to it
    // R9
    pend_fall_chk: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> ((~st_q.pend & $past(st_q.pend) & ~$past(clr_vec)) == '0));

    for (genvar i = 0; i < BANK_W; i++) begin : g_chk
        // R8
        disabled_code_chk: assert property (@(posedge clk) disable iff (!rst_n)
            $rose(st_q.pend[i]) |-> ($past(st_q.ctrl[i]) <= 3'd4));
        // R3
        level_high_chk: assert property (@(posedge clk) disable iff (!rst_n)
            (st_q.ctrl[i] == 3'd1 && cur_i[i]) |=> st_q.pend[i]);
    end

endmodule

// File: rtl/xint_front.sv
// Banked external interrupt front end: direct lines for the low banks,
// one combined line for the high banks
module xint_front import xint_pkg::*; #(
    parameter  int NUM_BANKS    = 4,
    parameter  int BANK_W       = 8,
    parameter  int DIRECT_BANKS = 2,
    localparam int NPINS        = NUM_BANKS * BANK_W,
    localparam int DATA_W       = BANK_W * FIELD_STRIDE,
    localparam int BANK_AW      = $clog2(NUM_BANKS),
    localparam int ADDR_W       = BANK_AW + 2,
    localparam int NDIRECT      = DIRECT_BANKS * BANK_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [NPINS-1:0]  pin_i,
    input  logic              reg_we,
    input  logic [ADDR_W-1:0] reg_addr,
    input  logic [DATA_W-1:0] reg_wdata,
    output logic [DATA_W-1:0] reg_rdata,
    output logic [NDIRECT-1:0] irq_direct,
    output logic              irq_shared
);

    logic [BANK_AW-1:0] bank_idx;
    regsel_e            sel;

    assign bank_idx = reg_addr[ADDR_W-1:2];
    assign sel      = regsel_e'(reg_addr[1:0]);

    logic [NUM_BANKS-1:0][DATA_W-1:0] ctrl_rd;
    logic [NUM_BANKS-1:0][BANK_W-1:0] mask_rd;
    logic [NUM_BANKS-1:0][BANK_W-1:0] pend_rd;
    logic [NUM_BANKS-1:0][BANK_W-1:0] active;
    logic [NUM_BANKS-1:0][BANK_W-1:0] cur_s;
    logic [NUM_BANKS-1:0][BANK_W-1:0] prev_s;
    logic [NUM_BANKS-1:0]             wr_ctrl, wr_mask, wr_pend;

    for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bank
        logic hit;
        assign hit        = reg_we && (bank_idx == BANK_AW'(b));
        assign wr_ctrl[b] = hit && (sel == SEL_CTRL);
        assign wr_mask[b] = hit && (sel == SEL_MASK);
        assign wr_pend[b] = hit && (sel == SEL_PEND);

        xint_sync #(.WIDTH(BANK_W)) sync_i (
            .clk    (clk),
            .rst_n  (rst_n),
            .pin_i  (pin_i[b*BANK_W +: BANK_W]),
            .cur_o  (cur_s[b]),
            .prev_o (prev_s[b])
        );

        xint_bank #(.BANK_W(BANK_W)) bank_i (
            .clk       (clk),
            .rst_n     (rst_n),
            .cur_i     (cur_s[b]),
            .prev_i    (prev_s[b]),
            .wr_ctrl_i (wr_ctrl[b]),
            .wr_mask_i (wr_mask[b]),
            .wr_pend_i (wr_pend[b]),
            .wdata_i   (reg_wdata),
            .ctrl_o    (ctrl_rd[b]),
            .mask_o    (mask_rd[b]),
            .pend_o    (pend_rd[b]),
            .active_o  (active[b])
        );
    end

    // Low banks: one line per pin
    for (genvar b = 0; b < DIRECT_BANKS; b++) begin : g_direct
        assign irq_direct[b*BANK_W +: BANK_W] = active[b];
    end

    // High banks: everything folded into one request
    always_comb begin
        irq_shared = 1'b0;
        for (int b = DIRECT_BANKS; b < NUM_BANKS; b++) begin
            irq_shared = irq_shared | (|active[b]);
        end
    end

    always_comb begin
        case (sel)
            SEL_CTRL: reg_rdata = ctrl_rd[bank_idx];
            SEL_MASK: reg_rdata = DATA_W'(mask_rd[bank_idx]);
            SEL_PEND: reg_rdata = DATA_W'(pend_rd[bank_idx]);
            default:  reg_rdata = '0;
        endcase
    end

    // R1: outputs stay quiet while every source is masked
    // R1
    all_masked_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (&mask_rd) |-> (irq_direct == '0 && !irq_shared));

endmodule

// File: tb/xint_front_tb_top.sv
`timescale 1ns/100ps
module xint_front_tb_top;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [31:0] pins = '0;
    logic        reg_we = 1'b0;
    logic [3:0]  reg_addr = 4'd2;
    logic [31:0] reg_wdata = '0;
    logic [31:0] reg_rdata;
    logic [15:0] irq_direct;
    logic        irq_shared;

    int checks = 0;
    int errors = 0;

    always #2.5 clk = ~clk;

    xint_front dut_i (
        .clk        (clk),
        .rst_n      (rst_n),
        .pin_i      (pins),
        .reg_we     (reg_we),
        .reg_addr   (reg_addr),
        .reg_wdata  (reg_wdata),
        .reg_rdata  (reg_rdata),
        .irq_direct (irq_direct),
        .irq_shared (irq_shared)
    );

    localparam logic [31:0] ALL_OFF = 32'h7777_7777;

    // {pin[4:0], code[2:0], before, after, expected pending}
    localparam logic [10:0] VECS [0:12] = '{
        {5'd2,  3'd1, 1'b0, 1'b1, 1'b1},
        {5'd9,  3'd0, 1'b1, 1'b0, 1'b1},
        {5'd12, 3'd1, 1'b0, 1'b0, 1'b0},
        {5'd17, 3'd3, 1'b0, 1'b1, 1'b1},
        {5'd20, 3'd3, 1'b1, 1'b0, 1'b0},
        {5'd26, 3'd2, 1'b1, 1'b0, 1'b1},
        {5'd30, 3'd2, 1'b0, 1'b1, 1'b0},
        {5'd7,  3'd4, 1'b0, 1'b1, 1'b1},
        {5'd15, 3'd4, 1'b1, 1'b0, 1'b1},
        {5'd21, 3'd5, 1'b0, 1'b1, 1'b0},
        {5'd31, 3'd7, 1'b1, 1'b0, 1'b0},
        {5'd0,  3'd6, 1'b0, 1'b1, 1'b0},
        {5'd24, 3'd0, 1'b1, 1'b1, 1'b0}
    };

    function automatic logic [3:0] adr(input int b, input int s);
        return 4'(b * 4 + s);
    endfunction

    function automatic string tag_of(input logic [2:0] code);
        case (code)
            3'd0:    return "R4";
            3'd1:    return "R3";
            3'd2:    return "R6";
            3'd3:    return "R5";
            3'd4:    return "R7";
            default: return "R8";
        endcase
    endfunction

    function automatic logic [31:0] field_word(input int bitpos, input logic [2:0] code);
        return (ALL_OFF & ~(32'hF << (4 * bitpos))) | (32'(code) << (4 * bitpos));
    endfunction

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [3:0] a, input logic [31:0] d);
        @(negedge clk);
        reg_we = 1'b1; reg_addr = a; reg_wdata = d;
        @(negedge clk);
        reg_we = 1'b0;
    endtask

    task automatic rd(input logic [3:0] a, output logic [31:0] d);
        @(negedge clk);
        reg_addr = a;
        #1 d = reg_rdata;
    endtask

    // pin change at a falling edge reaches pending three rising edges later
    task automatic settle();
        repeat (3) @(posedge clk);
        @(negedge clk);
    endtask

    initial begin
        #(5.0 * 150000);
        checks++; errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        logic [31:0] d;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        #1;
        check("R1 pending after reset", reg_rdata, 32'h0);
        check("R1 direct lines after reset", 32'(irq_direct), 32'h0);
        check("R1 shared line after reset", 32'(irq_shared), 32'h0);
        for (int b = 0; b < 4; b++) begin
            rd(adr(b, 0), d); check("R1 control reset", d, 32'h0);
            rd(adr(b, 1), d); check("R1 mask reset", d, 32'hFF);
        end
        // low-level default with pins low fires while masked
        rd(adr(0, 2), d);
        check("R10 capture while masked", d, 32'hFF);
        check("R10 masked lines quiet", {irq_shared, 15'h0, irq_direct}, 32'h0);

        for (int b = 0; b < 4; b++) begin
            wr(adr(b, 0), ALL_OFF);
            wr(adr(b, 2), 32'hFF);
        end

        // control field layout and unstored bits
        wr(adr(1, 0), 32'hFFFF_FFFF);
        rd(adr(1, 0), d); check("R2 spare nibble bit", d, 32'h7777_7777);
        wr(adr(1, 0), 32'h1234_5678);
        rd(adr(1, 0), d); check("R2 field positions", d, 32'h1234_5670);
        wr(adr(1, 0), ALL_OFF);
        wr(adr(1, 2), 32'hFF);
        rd(adr(2, 3), d); check("R2 unused select", d, 32'h0);

        // table of trigger patterns
        for (int v = 0; v < 13; v++) begin
            int p, b, bp;
            logic [2:0] code;
            logic bf, af, ex;
            p = int'(VECS[v][10:6]); code = VECS[v][5:3];
            bf = VECS[v][2]; af = VECS[v][1]; ex = VECS[v][0];
            b = p / 8; bp = p % 8;
            @(negedge clk); pins[p] = bf;
            settle();
            wr(adr(b, 0), field_word(bp, code));
            wr(adr(b, 2), 32'hFF);
            wr(adr(b, 1), 32'hFF & ~(32'h1 << bp));
            pins[p] = af;
            settle();
            rd(adr(b, 2), d);
            check(tag_of(code), 32'(d[bp]), 32'(ex));
            if (p < 16) begin
                check("R11 direct line", {irq_shared, 15'h0, irq_direct},
                      32'(ex) << p);
            end else begin
                check("R12 shared line", {irq_shared, 15'h0, irq_direct},
                      32'(ex) << 31);
            end
            pins[p] = 1'b0;
            wr(adr(b, 0), ALL_OFF);
            wr(adr(b, 1), 32'hFF);
            settle();
            wr(adr(b, 2), 32'hFF);
        end

        // level re-asserts after a clear
        wr(adr(0, 0), field_word(4, 3'd1));
        pins[4] = 1'b1;
        settle();
        wr(adr(0, 2), 32'h10);
        rd(adr(0, 2), d); check("R3 re-assert while high", d, 32'h10);
        // writing zero keeps, writing one clears
        wr(adr(0, 0), ALL_OFF);
        wr(adr(0, 2), 32'h00);
        rd(adr(0, 2), d); check("R9 zero write keeps", d, 32'h10);
        wr(adr(0, 2), 32'h10);
        rd(adr(0, 2), d); check("R9 one write clears", d, 32'h0);
        pins[4] = 1'b0;
        settle();

        // rising edge does not repeat while held
        wr(adr(2, 0), field_word(2, 3'd3));
        wr(adr(2, 2), 32'hFF);
        pins[18] = 1'b1;
        settle();
        rd(adr(2, 2), d); check("R5 edge captured", d, 32'h04);
        wr(adr(2, 2), 32'h04);
        settle();
        rd(adr(2, 2), d); check("R5 no repeat while high", d, 32'h0);
        pins[18] = 1'b0;
        settle();

        // event and clear meet on the same edge
        @(negedge clk); pins[18] = 1'b1;
        repeat (2) @(posedge clk);
        @(negedge clk);
        reg_we = 1'b1; reg_addr = adr(2, 2); reg_wdata = 32'h04;
        @(negedge clk); reg_we = 1'b0;
        rd(adr(2, 2), d); check("R9 set wins over clear", d, 32'h04);
        wr(adr(2, 2), 32'h04);

        // latency through the synchronizer
        wr(adr(2, 0), field_word(2, 3'd4));
        wr(adr(2, 2), 32'hFF);
        reg_addr = adr(2, 2);
        pins[18] = 1'b0;
        repeat (2) @(posedge clk);
        @(negedge clk); #1;
        check("R13 not yet pending", reg_rdata, 32'h0);
        @(posedge clk);
        @(negedge clk); #1;
        check("R13 pending on third edge", reg_rdata, 32'h04);
        wr(adr(2, 0), ALL_OFF);
        wr(adr(2, 2), 32'hFF);

        // masking of the shared line
        wr(adr(2, 0), field_word(1, 3'd1));
        wr(adr(3, 0), field_word(5, 3'd1));
        pins[17] = 1'b1; pins[29] = 1'b1;
        settle();
        check("R10 shared masked", 32'(irq_shared), 32'h0);
        rd(adr(3, 2), d); check("R10 masked pending kept", d, 32'h20);
        wr(adr(2, 1), 32'hFD);
        check("R12 bank 2 source", 32'(irq_shared), 32'h1);
        wr(adr(3, 1), 32'hDF);
        wr(adr(2, 1), 32'hFF);
        check("R12 bank 3 source", 32'(irq_shared), 32'h1);
        wr(adr(3, 1), 32'hFF);
        check("R10 shared remasked", 32'(irq_shared), 32'h0);
        pins[17] = 1'b0; pins[29] = 1'b0;
        wr(adr(2, 0), ALL_OFF);
        wr(adr(3, 0), ALL_OFF);

        // a direct line and its neighbours
        wr(adr(0, 0), field_word(1, 3'd1));
        pins[1] = 1'b1;
        settle();
        check("R11 masked direct", 32'(irq_direct), 32'h0);
        wr(adr(0, 1), 32'hFD);
        check("R11 unmasked direct", 32'(irq_direct), 32'h0002);
        pins[1] = 1'b0;
        wr(adr(0, 0), ALL_OFF);
        settle();
        wr(adr(0, 2), 32'hFF);
        check("R11 cleared direct", 32'(irq_direct), 32'h0);

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule